// File: doc/BRIEF.md
# Quad DAC Serial Register Front-End

This block is the digital front end of a four-channel, 12-bit converter. Slow external pins arrive at the block: serial data, a serial clock, an active-low chip select, two active-low load strobes, an active-low reset and a reset-code select. A fast system clock samples all of them. Chip select and serial clock are ORed, and each rising edge of the OR moves one bit into a 16-bit shift word. The first two bits of a word address a channel. The next two bits are padding. The last twelve bits are the code, most significant bit first.

Storage is double buffered. Each channel has an input register and an output register. While the register-load strobe is low, the input register selected by the live address bits of the shift word follows the code bits. While the output-load strobe is low, all four output registers follow their input registers. Both strobes act as level-sensitive enables, not edge loads. A low on the reset pin asynchronously forces all eight registers to zero-scale or mid-scale and leaves the shift word alone. The four output codes go to the analog converters.

Top module: `qdac_frontend`

## Requirements
- R1: While rstN is low with resetSel low, every input and output register holds 000h. After rstN rises with both load strobes high, the outputs keep 000h, and a later output-load pulse still shows 000h.
- R2: While rstN is low with resetSel high, every register holds 800h (bit 11 set, all other bits clear).
- R3: A word is 16 bits. Bits 15..14 are the channel address (0 to 3) and bits 13..12 are ignored. Bits 11..0 are the code. Channel n appears on dacCodes[12n+11:12n].
- R4: The shift word advances by one bit, taking sdi, on each rising edge of (chipSelN OR sclk). The word can be clocked by sclk with chipSelN low, or by chipSelN with sclk low.
- R5: If chipSelN rises while sclk is low, the block takes one extra bit.
- R6: While loadRegN is low, the input register addressed by the shift word follows the code bits. While loadRegN is high, the input registers hold. Outputs do not change while loadDacsN stays high.
- R7: Shifting while loadRegN is low overwrites every input register that the moving address bits select along the way.
- R8: While loadDacsN is low, every output register follows its input register. While loadDacsN is high, the outputs hold. Keeping loadDacsN low makes a channel update on its register-load pulse alone.
- R9: Reset takes priority over both load strobes and does not alter the shift word. After reset, a register load writes the word that was shifted in before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system sampling clock |
| rstN | input | 1 | Asynchronous active-low register reset pin |
| resetSel | input | 1 | Reset code select: 0 = zero-scale, 1 = mid-scale |
| sdi | input | 1 | Serial data pin |
| sclk | input | 1 | Serial clock pin |
| chipSelN | input | 1 | Active-low chip select, ORed with sclk |
| loadRegN | input | 1 | Active-low input-register enable |
| loadDacsN | input | 1 | Active-low output-register enable |
| dacCodes | output | 48 | Four 12-bit output codes, channel 0 in the low bits |

## Verification
The assertions check four properties on every cycle. The outputs hold while the output enable is off. The address bits move only on a shift-clock edge and never while reset is low. At most one input register is written at a time. The reset code matches the select pin. Only the bench scenarios can show that a whole word lands in the right channel. The bench also shows the extra bit from a late chip-select rise, the corruption of every register selected during live shifting, and the word surviving a reset, all checked against its own pin-level model.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int ADDR_W   = 2;
  localparam int CHANNELS = 1 << ADDR_W;

  typedef struct packed {
    logic                shiftEn;
    logic                outLoad;
    logic [CHANNELS-1:0] wrEn;
  } qdac_strb_t;
endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
  parameter int                 WIDTH   = 5,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinsIn,
  output logic [WIDTH-1:0] pinsOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RST_VAL;
      else if (s == 0) stageQ[s] <= pinsIn;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s - 1];
    end
  end

  assign pinsOut = stageQ[STAGES-1];
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csSync,
  input  logic              sclkSync,
  input  logic              loadRegSyncN,
  input  logic              loadDacsSyncN,
  input  logic [ADDR_W-1:0] frameAddr,
  output qdac_strb_t        strb
);
  logic orNow;
  logic orPrev;

  assign orNow = csSync | sclkSync;

  // The previous OR value resets high so reset release never makes an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) orPrev <= 1'b1;
    else       orPrev <= orNow;
  end

  assign strb.shiftEn = orNow & ~orPrev;
  assign strb.outLoad = ~loadDacsSyncN;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_dec
    assign strb.wrEn[c] = ~loadRegSyncN && (frameAddr == ADDR_W'(c));
  end
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int PAD_W  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         resetSel,
  input  qdac_strb_t                   strb,
  input  logic                         sdiBit,
  output logic [ADDR_W-1:0]            frameAddr,
  output logic [CHANNELS*CODE_W-1:0]   dacCodes
);
  localparam int WORD_W = ADDR_W + PAD_W + CODE_W;

  logic [WORD_W-1:0] shiftWord;
  logic [CODE_W-1:0] rstCode;
  logic [CODE_W-1:0] inReg  [CHANNELS];
  logic [CODE_W-1:0] outReg [CHANNELS];

  assign rstCode = {resetSel, {(CODE_W-1){1'b0}}};

  // The shift word is deliberately outside the reset.
  always_ff @(posedge clk) begin
    if (strb.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], sdiBit};
  end

  assign frameAddr = shiftWord[WORD_W-1 -: ADDR_W];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              inReg[c] <= rstCode;
      else if (strb.wrEn[c])  inReg[c] <= shiftWord[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             outReg[c] <= rstCode;
      else if (strb.outLoad) outReg[c] <= inReg[c];
    end

    assign dacCodes[c*CODE_W +: CODE_W] = outReg[c];
  end
endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
  import qdac_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       resetSel,
  input  logic                       sdi,
  input  logic                       sclk,
  input  logic                       chipSelN,
  input  logic                       loadRegN,
  input  logic                       loadDacsN,
  output logic [CHANNELS*CODE_W-1:0] dacCodes
);
  localparam int PIN_W = 5;

  logic [PIN_W-1:0] pinsRaw;
  logic [PIN_W-1:0] pinsSync;
  logic [ADDR_W-1:0] frameAddr;
  qdac_strb_t        strb;

  assign pinsRaw = {sdi, sclk, chipSelN, loadRegN, loadDacsN};

  qdac_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(5'b01111)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinsIn (pinsRaw),
    .pinsOut(pinsSync)
  );

  qdac_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .csSync       (pinsSync[2]),
    .sclkSync     (pinsSync[3]),
    .loadRegSyncN (pinsSync[1]),
    .loadDacsSyncN(pinsSync[0]),
    .frameAddr    (frameAddr),
    .strb         (strb)
  );

  qdac_datapath #(
    .CODE_W(CODE_W),
    .PAD_W (PAD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .resetSel (resetSel),
    .strb     (strb),
    .sdiBit   (pinsSync[4]),
    .frameAddr(frameAddr),
    .dacCodes (dacCodes)
  );
endmodule

// File: rtl/qdac_frontend_chk.sv
module qdac_frontend_chk
  import qdac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       resetSel,
  input qdac_strb_t                 strb,
  input logic [ADDR_W-1:0]          frameAddr,
  input logic [CHANNELS*CODE_W-1:0] dacCodes
);
  logic [CHANNELS*CODE_W-1:0] rstAll;
  assign rstAll = {CHANNELS{resetSel, {(CODE_W-1){1'b0}}}};

  AST_RESET_CODE: assert property (@(posedge clk)
    (!rstN && $past(!rstN) && $stable(resetSel)) |-> (dacCodes == rstAll)) // R1 R2
    else $error("reset code mismatch");

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.outLoad |=> $stable(dacCodes)) // R8
    else $error("outputs moved without output load");

  AST_SHIFT_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(frameAddr)) // R4
    else $error("shift word moved without edge");

  AST_SHIFT_KEPT_IN_RESET: assert property (@(posedge clk)
    (!rstN && $past(!rstN)) |=> $stable(frameAddr)) // R9
    else $error("shift word changed in reset");

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrEn)) // R6
    else $error("more than one input register written");
endmodule

bind qdac_frontend qdac_frontend_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .resetSel (resetSel),
  .strb     (strb),
  .frameAddr(frameAddr),
  .dacCodes (dacCodes)
);

// File: tb/qdac_frontend_test.sv
module qdac_frontend_test;
  logic clk = 1'b0;
  logic rstN = 1'b0, resetSel = 1'b0, sdi = 1'b0, sclk = 1'b1, chipSelN = 1'b1;
  logic loadRegN = 1'b1, loadDacsN = 1'b1;
  logic [47:0] dacCodes;
  int   tests = 0, fails = 0;
  bit   finished = 1'b0;

  logic [15:0] srM;
  logic [11:0] inM  [4];
  logic [11:0] outM [4];

  // {word, expected channel, expected code}
  localparam logic [29:0] VEC [0:4] = '{
    {16'h0ABC, 2'd0, 12'hABC},
    {16'h7123, 2'd1, 12'h123},
    {16'h8FFF, 2'd2, 12'hFFF},
    {16'hC800, 2'd3, 12'h800},
    {16'h3001, 2'd0, 12'h001}
  };

  always #2 clk = ~clk;

  qdac_frontend uut (
    .clk(clk), .rstN(rstN), .resetSel(resetSel), .sdi(sdi), .sclk(sclk),
    .chipSelN(chipSelN), .loadRegN(loadRegN), .loadDacsN(loadDacsN),
    .dacCodes(dacCodes)
  );

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int c = 0; c < 4; c++) check(tag, dacCodes[c*12 +: 12], outM[c]);
  endtask

  task automatic modelCopy();
    for (int c = 0; c < 4; c++) outM[c] = inM[c];
  endtask

  task automatic modelShift(logic b);
    srM = {srM[14:0], b};
    if (!loadRegN) inM[srM[15:14]] = srM[11:0];
    if (!loadDacsN) modelCopy();
  endtask

  task automatic modelReset(logic sel);
    for (int c = 0; c < 4; c++) begin
      inM[c] = {sel, 11'h0};
      outM[c] = {sel, 11'h0};
    end
  endtask

  task automatic setLoadReg(logic v);
    loadRegN = v;
    if (!v) begin
      inM[srM[15:14]] = srM[11:0];
      if (!loadDacsN) modelCopy();
    end
    step();
  endtask

  task automatic setLoadDacs(logic v);
    loadDacsN = v;
    if (!v) modelCopy();
    step();
  endtask

  // mode 0: sclk clocks; 1: chip select clocks; 2: sclk left low at the end
  task automatic sendWord(logic [15:0] w, int mode);
    if (mode == 1) begin
      sclk = 1'b0; step();
      for (int i = 15; i >= 0; i--) begin
        chipSelN = 1'b0; sdi = w[i]; step();
        chipSelN = 1'b1; modelShift(w[i]); step();
      end
      sclk = 1'b1; step();
    end else begin
      chipSelN = 1'b0; step();
      for (int i = 15; i >= 0; i--) begin
        sclk = 1'b0; sdi = w[i]; step();
        sclk = 1'b1; modelShift(w[i]); step();
      end
      if (mode == 2) begin
        sclk = 1'b0; step();
        chipSelN = 1'b1; modelShift(sdi); step();
        sclk = 1'b1; step();
      end else begin
        chipSelN = 1'b1; step();
      end
    end
  endtask

  initial begin
    srM = '0;
    modelReset(1'b0);
    step();
    // R1: zero-scale reset state
    checkAll("R1 reset zero-scale");
    rstN = 1'b1; step();
    setLoadDacs(1'b0); setLoadDacs(1'b1);
    checkAll("R1 after release and load");

    // R3 R6 R8: table of words
    for (int i = 0; i < 5; i++) begin
      sendWord(VEC[i][29:14], 0);
      setLoadReg(1'b0); setLoadReg(1'b1);
      checkAll("R6 outputs hold with output load high");
      setLoadDacs(1'b0); setLoadDacs(1'b1);
      check("R3 channel code", dacCodes[VEC[i][13:12]*12 +: 12], VEC[i][11:0]);
      checkAll("R8 all channels");
    end

    // R4: chip select as shift clock
    sendWord(16'h4555, 1);
    setLoadReg(1'b0); setLoadReg(1'b1);
    setLoadDacs(1'b0); setLoadDacs(1'b1);
    check("R4 chip-select clocked word", dacCodes[12 +: 12], 12'h555);
    checkAll("R4 all channels");

    // R5: chip select rises with sclk low -> extra bit, address becomes 2
    sendWord(16'h4123, 2);
    setLoadReg(1'b0); setLoadReg(1'b1);
    setLoadDacs(1'b0); setLoadDacs(1'b1);
    check("R5 extra shift lands in channel 2", dacCodes[24 +: 12], 12'h247);
    checkAll("R5 all channels");

    // R8: output load held low, register load alone updates
    setLoadDacs(1'b0);
    sendWord(16'hC6A5, 0);
    checkAll("R8 no update before register load");
    setLoadReg(1'b0); setLoadReg(1'b1);
    check("R8 transparent output", dacCodes[36 +: 12], 12'h6A5);
    setLoadDacs(1'b1);

    // R7: shifting with register load low corrupts each selected register
    setLoadReg(1'b0);
    sendWord(16'h5A3C, 0);
    setLoadReg(1'b1);
    setLoadDacs(1'b0); setLoadDacs(1'b1);
    checkAll("R7 live address corruption");

    // R2 R9: mid-scale reset keeps the pending shift word
    sendWord(16'hB3C5, 0);
    resetSel = 1'b1; rstN = 1'b0; modelReset(1'b1); step();
    checkAll("R2 reset mid-scale");
    rstN = 1'b1; step();
    setLoadDacs(1'b0); setLoadDacs(1'b1);
    checkAll("R2 mid-scale kept after release");
    setLoadReg(1'b0); setLoadReg(1'b1);
    setLoadDacs(1'b0); setLoadDacs(1'b1);
    check("R9 shift word survives reset", dacCodes[24 +: 12], 12'h3C5);

    // R9: reset overrides both enables held low
    loadRegN = 1'b0; loadDacsN = 1'b0; step();
    resetSel = 1'b0; rstN = 1'b0; modelReset(1'b0); step();
    checkAll("R9 reset priority over enables");
    loadRegN = 1'b1; loadDacsN = 1'b1; step();
    rstN = 1'b1; step();
    checkAll("R9 reset code held");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule